// File: doc/BRIEF.md
# Converter Start-up and Fault Sequencer

This block decides when a step-down converter is allowed to switch. It takes four conditions: an enable level, a flag that the supply has risen past its start threshold, a flag that the supply has dropped under its lower shutdown threshold, and an over-temperature flag. From these it walks a five-state sequence and releases the mode controller through a run-enable output. The gap between the start flag and the shutdown flag gives the supply hysteresis.

While the sequencer holds the soft-start state, it produces a digital reference code for the regulation loop. The code climbs linearly from zero to full scale, one step every `STEP_CYC` clocks. Normal regulation starts only once full scale is reached. Any loss of enable, supply or temperature margin clears the ramp at once.

Recovery from thermal shutdown is automatic, and it always goes through the whole timed ramp again. A parameter sets the step interval so that the ramp lands inside the required start-up window. At a 10 MHz clock, the default of 18 cycles per step over 255 steps gives about 459 µs end to end. The 5 % to 95 % portion of that is about 413 µs.

Top module: `buck_start_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `state_o` reads 0 (off), and `run_en_o`, `ramp_done_o` and `ref_code_o` are all 0.
- R2: Enable has the highest priority. When `en_i` is low at a clock edge, `state_o` is 0 after that edge, whatever the other inputs are, and `run_en_o` and `ref_code_o` are 0.
- R3: From off, with `en_i` high and no over-temperature, the state becomes 1 (waiting for supply) after one edge. It stays at 1 while `vs_start_i` is low.
- R4: From waiting, with `vs_start_i` high, the state becomes 2 (soft start). `run_en_o` rises on that same edge and `ref_code_o` starts at 0.
- R5: In soft start the code rises by exactly one after every `STEP_CYC` edges spent in that state. It never skips a value and never falls while the state holds.
- R6: The code reaches full scale (2^`CODE_W`−1) after `STEP_CYC`×(2^`CODE_W`−1) edges in soft start. One edge later the state is 3 (run) and `ramp_done_o` is 1. In run the code holds at full scale.
- R7: With enable high and no over-temperature, `vs_low_i` high in soft start or run sends the state to 1. `run_en_o` and the code drop to 0 on that edge. A later start runs the ramp from 0.
- R8: With `en_i` high, `hot_i` high sends the state to 4 (thermal off) from any state. `run_en_o` and the code are 0 there. Over-temperature outranks the supply flags.
- R9: When `hot_i` clears in thermal off, the state returns to 1. Run is reached only after a complete soft-start ramp from code 0. Run is never entered from any state other than soft start.
- R10: `state_o` encodes off=0, waiting=1, soft start=2, run=3, thermal off=4. `run_en_o` is 1 exactly in states 2 and 3, and `ramp_done_o` is 1 exactly in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enable level; low forces off |
| vs_start_i | input | 1 | Supply above the start threshold |
| vs_low_i | input | 1 | Supply below the shutdown threshold |
| hot_i | input | 1 | Over-temperature flag |
| run_en_o | output | 1 | Converter may switch |
| ref_code_o | output | CODE_W | Soft-start reference code |
| ramp_done_o | output | 1 | Ramp complete, normal regulation |
| state_o | output | 3 | Sequencer state code |

## Verification
The properties assume the condition inputs are already synchronous to `clk` and change only between edges. They also assume that enable, temperature and supply priority are resolved purely from levels sampled at each edge. The bench drives every input on the falling clock edge and samples on the falling edge that follows, so each check sees the result of exactly one rising edge. The start and shutdown flags are never both high in a way that would contradict a real comparator pair, except in the deliberate priority test. In that test over-temperature and a supply drop arrive together.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_OFF  = 3'd0,
        SEQ_WAIT = 3'd1,
        SEQ_RAMP = 3'd2,
        SEQ_RUN  = 3'd3,
        SEQ_HOT  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic en;
        logic vs_ok;
        logic vs_low;
        logic hot;
    } seq_cond_t;

    function automatic logic is_switching(input seq_state_e s);
        return (s == SEQ_RAMP) || (s == SEQ_RUN);
    endfunction

    // Transition rule: enable, then temperature, then supply, then ramp progress.
    function automatic seq_state_e next_state(input seq_state_e s,
                                              input seq_cond_t  c,
                                              input logic       ramp_full);
        seq_state_e n;
        n = s;
        if (!c.en) begin
            n = SEQ_OFF;
        end else if (c.hot) begin
            n = SEQ_HOT;
        end else begin
            case (s)
                SEQ_OFF:  n = SEQ_WAIT;
                SEQ_WAIT: n = c.vs_ok ? SEQ_RAMP : SEQ_WAIT;
                SEQ_RAMP: begin
                    if (c.vs_low)       n = SEQ_WAIT;
                    else if (ramp_full) n = SEQ_RUN;
                    else                n = SEQ_RAMP;
                end
                SEQ_RUN:  n = c.vs_low ? SEQ_WAIT : SEQ_RUN;
                SEQ_HOT:  n = SEQ_WAIT;
                default:  n = SEQ_OFF;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import buck_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_cond_t  cond,
    input  logic       ramp_full,
    output seq_state_e state_q,
    output seq_state_e state_nxt
);

    always_comb begin
        state_nxt = next_state(state_q, cond, ramp_full);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_OFF;
        end else begin
            state_q <= state_nxt;
        end
    end

endmodule

// File: rtl/soft_ramp.sv
module soft_ramp
    import buck_seq_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int STEP_CYC = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state_q,
    input  seq_state_e        state_nxt,
    output logic [CODE_W-1:0] code,
    output logic              full
);

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam int TICK_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

    logic keep;
    logic ramping;
    logic step_hit;

    assign keep    = is_switching(state_nxt);
    assign ramping = (state_q == SEQ_RAMP);
    assign full    = (code == CODE_MAX);

    generate
        if (STEP_CYC > 1) begin : g_div
            localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(STEP_CYC - 1);
            logic [TICK_W-1:0] tick;

            assign step_hit = (tick == TICK_LAST);

            always_ff @(posedge clk) begin
                if (rst || !keep) begin
                    tick <= '0;
                end else if (ramping) begin
                    tick <= step_hit ? '0 : tick + 1'b1;
                end
            end
        end else begin : g_nodiv
            assign step_hit = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !keep) begin
            code <= '0;
        end else if (ramping && step_hit && !full) begin
            code <= code + 1'b1;
        end
    end

endmodule

// File: rtl/buck_start_seq.sv
module buck_start_seq
    import buck_seq_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int STEP_CYC = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              vs_start_i,
    input  logic              vs_low_i,
    input  logic              hot_i,
    output logic              run_en_o,
    output logic [CODE_W-1:0] ref_code_o,
    output logic              ramp_done_o,
    output logic [2:0]        state_o
);

    seq_cond_t  cond;
    seq_state_e st_q;
    seq_state_e st_n;
    logic       full;

    assign cond.en     = en_i;
    assign cond.vs_ok  = vs_start_i;
    assign cond.vs_low = vs_low_i;
    assign cond.hot    = hot_i;

    seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cond      (cond),
        .ramp_full (full),
        .state_q   (st_q),
        .state_nxt (st_n)
    );

    soft_ramp #(
        .CODE_W   (CODE_W),
        .STEP_CYC (STEP_CYC)
    ) u_ramp (
        .clk       (clk),
        .rst       (rst),
        .state_q   (st_q),
        .state_nxt (st_n),
        .code      (ref_code_o),
        .full      (full)
    );

    assign run_en_o    = is_switching(st_q);
    assign ramp_done_o = (st_q == SEQ_RUN);
    assign state_o     = st_q;

endmodule

// File: rtl/buck_start_seq_chk.sv
module buck_start_seq_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en_i,
    input logic              vs_start_i,
    input logic              vs_low_i,
    input logic              hot_i,
    input logic              run_en_o,
    input logic [CODE_W-1:0] ref_code_o,
    input logic              ramp_done_o,
    input logic [2:0]        state_o
);

    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

    // R2
    enable_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (state_o == 3'd0) && !run_en_o && (ref_code_o == '0));

    // R8
    thermal_off_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && hot_i) |=> (state_o == 3'd4) && !run_en_o && (ref_code_o == '0));

    // R7
    supply_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && !hot_i && vs_low_i && (state_o == 3'd2 || state_o == 3'd3))
        |=> (state_o == 3'd1) && (ref_code_o == '0));

    // R4
    ramp_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_en_o) |-> (ref_code_o == '0) && (state_o == 3'd2));

    // R5
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 && $past(state_o) == 3'd2)
        |-> (ref_code_o == $past(ref_code_o) || ref_code_o == $past(ref_code_o) + 1'b1));

    // R6
    run_full_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3) |-> (ref_code_o == FULL) && ramp_done_o);

    // R9
    run_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ramp_done_o) |-> ($past(state_o) == 3'd2) && ($past(ref_code_o) == FULL));

endmodule

bind buck_start_seq buck_start_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .vs_start_i  (vs_start_i),
    .vs_low_i    (vs_low_i),
    .hot_i       (hot_i),
    .run_en_o    (run_en_o),
    .ref_code_o  (ref_code_o),
    .ramp_done_o (ramp_done_o),
    .state_o     (state_o)
);

// File: tb/sim_buck_start_seq.sv
module sim_buck_start_seq;

    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int STEP = 18;
    localparam int FULL = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         en, vs_ok, vs_low, hot;
    logic         run_en, done;
    logic [W-1:0] code;
    logic [2:0]   st;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    buck_start_seq #(.CODE_W(W), .STEP_CYC(STEP)) u0 (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en),
        .vs_start_i  (vs_ok),
        .vs_low_i    (vs_low),
        .hot_i       (hot),
        .run_en_o    (run_en),
        .ref_code_o  (code),
        .ramp_done_o (done),
        .state_o     (st)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // st, run_en, code, done in one call
    task automatic chk_all(input string req, input int s, input int r, input int c, input int d);
        chk({req, " state"}, int'(st), s);
        chk({req, " run_en"}, int'(run_en), r);
        chk({req, " code"}, int'(code), c);
        chk({req, " done"}, int'(done), d);
    endtask

    task automatic set_in(input logic e, input logic ok, input logic lo, input logic h);
        en = e; vs_ok = ok; vs_low = lo; hot = h;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        set_in(1'b1, 1'b1, 1'b0, 1'b0);
        step(3);
        chk_all("R1 in reset", 0, 0, 0, 0);
        set_in(1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        step(1);
        chk_all("R1 after reset", 0, 0, 0, 0);
    endtask

    task automatic t_wait_supply;
        set_in(1'b0, 1'b0, 1'b0, 1'b0);
        step(5);
        chk("R2 stays off", int'(st), 0);
        en = 1'b1;
        step(1);
        chk_all("R3 off to wait", 1, 0, 0, 0);
        step(10);
        chk_all("R3 wait holds", 1, 0, 0, 0);
    endtask

    // From waiting, runs the full ramp and checks every step.
    task automatic t_full_ramp(input string tag);
        int bad;
        bad = 0;
        vs_ok = 1'b1;
        step(1);
        chk_all({tag, " R4 ramp entry"}, 2, 1, 0, 0);
        for (int k = 1; k <= STEP * FULL; k++) begin
            step(1);
            if (int'(code) != k / STEP || st != 3'd2) bad++;
            if (k == STEP - 1) chk({tag, " R5 before first step"}, int'(code), 0);
            if (k == STEP)     chk({tag, " R5 first step"}, int'(code), 1);
        end
        chk({tag, " R5 ramp profile mismatches"}, bad, 0);
        chk_all({tag, " R6 full scale still ramping"}, 2, 1, FULL, 0);
        step(1);
        chk_all({tag, " R6 run entry"}, 3, 1, FULL, 1);
        step(20);
        chk_all({tag, " R6 run holds"}, 3, 1, FULL, 1);
    endtask

    task automatic t_supply_drop;
        vs_ok = 1'b0; vs_low = 1'b1;
        step(1);
        chk_all("R7 drop from run", 1, 0, 0, 0);
        vs_low = 1'b0; vs_ok = 1'b1;
        step(1);
        chk_all("R7 restart", 2, 1, 0, 0);
        step(STEP * 5 + 2);
        chk("R7 mid ramp code", int'(code), 5);
        vs_ok = 1'b0; vs_low = 1'b1;
        step(1);
        chk_all("R7 drop mid ramp", 1, 0, 0, 0);
        vs_low = 1'b0; vs_ok = 1'b1;
        step(1);
        chk_all("R7 ramp restarts at zero", 2, 1, 0, 0);
        step(STEP);
        chk("R7 first step again", int'(code), 1);
    endtask

    task automatic t_thermal;
        hot = 1'b1; vs_low = 1'b1;
        step(1);
        chk_all("R8 hot with supply drop", 4, 0, 0, 0);
        vs_low = 1'b0;
        step(15);
        chk_all("R8 hot holds", 4, 0, 0, 0);
        hot = 1'b0; vs_ok = 1'b0;
        step(1);
        chk_all("R9 cool to wait", 1, 0, 0, 0);
        t_full_ramp("R9 recovery");
    endtask

    task automatic t_enable_priority;
        hot = 1'b1;
        step(1);
        chk("R8 hot from run", int'(st), 4);
        en = 1'b0;
        step(1);
        chk_all("R2 enable over hot", 0, 0, 0, 0);
        set_in(1'b1, 1'b1, 1'b0, 1'b0);
        step(2);
        chk("R10 ramp code value", int'(st), 2);
        step(STEP * 3);
        en = 1'b0;
        step(1);
        chk_all("R2 enable drop mid ramp", 0, 0, 0, 0);
        set_in(1'b1, 1'b0, 1'b0, 1'b1);
        step(1);
        chk_all("R8 hot from off", 4, 0, 0, 0);
    endtask

    initial begin
        set_in(1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b1;
        step(1);
        t_reset();
        t_wait_supply();
        t_full_ramp("R6 first start");
        t_supply_drop();
        vs_ok = 1'b0;
        en = 1'b0;
        step(1);
        en = 1'b1;
        step(1);
        t_full_ramp("R6 second start");
        t_thermal();
        t_enable_priority();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule